// File: doc/BRIEF.md
# Interrupt Enable and Flag Register Pair with Two Reset Classes

This block holds the interrupt-enable byte and the interrupt-flag byte of a small microcontroller. Both sit on a simple peripheral bus made of a byte address, a write strobe, write data and read data. Reads are combinational from the current address. Writes take effect at the next rising clock edge. Hardware event pulses from the watchdog, the oscillator monitor and the non-maskable input set their flags. Software can read and write every implemented bit.

Each bit belongs to one of two reset classes. The first is an asynchronous power-on reset. The second is a lighter power-up-clear, which any system reset raises as a one-cycle pulse. A power-on reset also performs everything a power-up-clear does. Some flags come out of reset at 1, and others record whether the last reset came from power-on or from the reset pin. Software can therefore read the flag byte to learn the cause of a restart.

The block also drives one interrupt request per source, each gated by its enable. The watchdog request is further gated by the watchdog's interval-timer mode.

Top module: `sysirq_regs`

## Requirements
- R1: The enable byte is at address 0x00, with watchdog in bit 0, oscillator fault in bit 1, non-maskable in bit 4 and flash access violation in bit 5. The flag byte is at address 0x02, with watchdog in bit 0, oscillator fault in bit 1, power-on in bit 2, pin reset in bit 3 and non-maskable in bit 4. Read data follows the address in the same cycle, and every other address reads 0x00.
- R2: Unallocated bits (enable bits 2, 3, 6, 7 and flag bits 5, 6, 7) always read 0, and writes to them have no effect.
- R3: While power-on reset is low, the enable byte is 0x00 and the flag byte is 0x06: oscillator-fault and power-on flags at 1, all other flags at 0.
- R4: In a power-up-clear cycle (puc_i or pin_rst_i high), the enable byte clears, the non-maskable flag clears, the oscillator-fault flag is set and the power-on flag keeps its value. A bus write in that same cycle is ignored.
- R5: A pin reset sets the pin-reset flag and clears the watchdog flag, unless a watchdog event arrives in the same cycle. A plain power-up-clear leaves the watchdog and pin-reset flags unchanged.
- R6: A bus write to an implemented bit loads that bit at the next edge. Writing 0 is the only way to clear the power-on flag outside power-on reset.
- R7: A watchdog, oscillator-fault or non-maskable event pulse sets its flag at the next edge. It wins over a bus write to the same flag in the same cycle. The watchdog event also wins during power-up-clear.
- R8: irq_osc_o, irq_nmi_o and irq_acv_o are the AND of each source's flag and enable. The access-violation flag is the level input acv_flag_i. These requests are combinational from the registers.
- R9: irq_wdt_o is high only when the watchdog flag, the watchdog enable and wdt_itmode_i are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Asynchronous power-on reset, active low |
| puc_i | input | 1 | Power-up-clear pulse from any system reset |
| pin_rst_i | input | 1 | Reset from the reset pin in reset mode; also acts as power-up-clear |
| addr_i | input | ADDR_W (8) | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| wdt_evt_i | input | 1 | Watchdog overflow or key violation pulse |
| osc_fault_i | input | 1 | Oscillator fault pulse |
| nmi_evt_i | input | 1 | Non-maskable event pulse |
| acv_flag_i | input | 1 | Flash access-violation flag level |
| wdt_itmode_i | input | 1 | Watchdog is in interval-timer mode |
| irq_wdt_o | output | 1 | Watchdog interrupt request |
| irq_osc_o | output | 1 | Oscillator-fault interrupt request |
| irq_nmi_o | output | 1 | Non-maskable interrupt request |
| irq_acv_o | output | 1 | Access-violation interrupt request |

## Verification
Directed sequences first write all ones and then all zeros to both addresses. This separates implemented bits from absent ones and exposes the reset value of each flag. Collisions are driven on purpose: an event in the same cycle as a clearing write, a write during power-up-clear, and a pin reset with and without a watchdog event. Each collision is settled by exactly one priority rule. A plain power-up-clear and a pin reset are applied to the same flag pattern, and power-on reset is asserted in the middle of the run, so the two reset classes show distinct flag bytes. A long stretch of random writes, events and resets is then compared every cycle against the bench's behavioural model.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;
    localparam int DW = 8;

    // enable byte bit positions (software-visible layout)
    localparam int EN_WDT = 0;
    localparam int EN_OSC = 1;
    localparam int EN_NMI = 4;
    localparam int EN_ACV = 5;

    // flag byte bit positions
    localparam int FL_WDT = 0;
    localparam int FL_OSC = 1;
    localparam int FL_POR = 2;
    localparam int FL_PIN = 3;
    localparam int FL_NMI = 4;

    localparam int NSRC = 4;

    typedef struct packed {
        logic wdt;
        logic osc;
        logic nmi;
        logic acv;
    } en_t;

    typedef struct packed {
        logic wdt;
        logic osc;
        logic por;
        logic pin;
        logic nmi;
    } fl_t;

    localparam en_t EN_RST = '{wdt: 1'b0, osc: 1'b0, nmi: 1'b0, acv: 1'b0};
    localparam fl_t FL_RST = '{wdt: 1'b0, osc: 1'b1, por: 1'b1, pin: 1'b0, nmi: 1'b0};
endpackage

// File: rtl/sysirq_enable_reg.sv
module sysirq_enable_reg
    import sysirq_pkg::*;
(
    input  logic clk,
    input  logic rst_por_n,
    input  logic clr_i,
    input  logic wr_i,
    input  en_t  wval_i,
    output en_t  en_o
);
    typedef struct packed {
        en_t en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.en = EN_RST;
        end else if (wr_i) begin
            st_d.en = wval_i;
        end
    end

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) begin
            st_q.en <= EN_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/sysirq_flag_reg.sv
module sysirq_flag_reg
    import sysirq_pkg::*;
(
    input  logic clk,
    input  logic rst_por_n,
    input  logic clr_i,
    input  logic pin_i,
    input  logic wr_i,
    input  fl_t  wval_i,
    input  logic set_wdt_i,
    input  logic set_osc_i,
    input  logic set_nmi_i,
    output fl_t  fl_o
);
    typedef struct packed {
        fl_t fl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // software load, suppressed while a power-up-clear is in progress
        if (wr_i && !clr_i) begin
            st_d.fl = wval_i;
        end
        // hardware set events override the software value
        if (set_wdt_i) st_d.fl.wdt = 1'b1;
        if (set_osc_i) st_d.fl.osc = 1'b1;
        if (set_nmi_i) st_d.fl.nmi = 1'b1;
        // power-up-clear class
        if (clr_i) begin
            st_d.fl.nmi = 1'b0;
            st_d.fl.osc = 1'b1;
        end
        // reset-pin cause record
        if (pin_i) begin
            st_d.fl.pin = 1'b1;
            st_d.fl.wdt = set_wdt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) begin
            st_q.fl <= FL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign fl_o = st_q.fl;
endmodule

// File: rtl/sysirq_req_gate.sv
module sysirq_req_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] qual_i,
    output logic [N-1:0] req_o
);
    for (genvar g = 0; g < N; g++) begin : g_src
        assign req_o[g] = flag_i[g] & en_i[g] & qual_i[g];
    end
endmodule

// File: rtl/sysirq_regs.sv
module sysirq_regs
    import sysirq_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] FL_ADDR = 'h02
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              puc_i,
    input  logic              pin_rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic              wdt_evt_i,
    input  logic              osc_fault_i,
    input  logic              nmi_evt_i,
    input  logic              acv_flag_i,
    input  logic              wdt_itmode_i,
    output logic              irq_wdt_o,
    output logic              irq_osc_o,
    output logic              irq_nmi_o,
    output logic              irq_acv_o
);
    localparam int SRC_WDT = 0;
    localparam int SRC_OSC = 1;
    localparam int SRC_NMI = 2;
    localparam int SRC_ACV = 3;

    logic clr;
    logic wr_en_hit, wr_fl_hit;
    en_t  en_w, en_q;
    fl_t  fl_w, fl_q;
    logic [DW-1:0] en_byte, fl_byte;
    logic [NSRC-1:0] src_flag, src_en, src_qual, src_req;
    logic unused_wdata;

    assign clr       = puc_i | pin_rst_i;
    assign wr_en_hit = wr_en_i && (addr_i == EN_ADDR);
    assign wr_fl_hit = wr_en_i && (addr_i == FL_ADDR);

    assign en_w = '{wdt: wdata_i[EN_WDT], osc: wdata_i[EN_OSC],
                    nmi: wdata_i[EN_NMI], acv: wdata_i[EN_ACV]};
    assign fl_w = '{wdt: wdata_i[FL_WDT], osc: wdata_i[FL_OSC], por: wdata_i[FL_POR],
                    pin: wdata_i[FL_PIN], nmi: wdata_i[FL_NMI]};
    assign unused_wdata = ^{wdata_i[7:6], wdata_i[3:2]};

    sysirq_enable_reg u_en (
        .clk       (clk),
        .rst_por_n (rst_por_n),
        .clr_i     (clr),
        .wr_i      (wr_en_hit),
        .wval_i    (en_w),
        .en_o      (en_q)
    );

    sysirq_flag_reg u_fl (
        .clk       (clk),
        .rst_por_n (rst_por_n),
        .clr_i     (clr),
        .pin_i     (pin_rst_i),
        .wr_i      (wr_fl_hit),
        .wval_i    (fl_w),
        .set_wdt_i (wdt_evt_i),
        .set_osc_i (osc_fault_i),
        .set_nmi_i (nmi_evt_i),
        .fl_o      (fl_q)
    );

    always_comb begin
        en_byte         = '0;
        en_byte[EN_WDT] = en_q.wdt;
        en_byte[EN_OSC] = en_q.osc;
        en_byte[EN_NMI] = en_q.nmi;
        en_byte[EN_ACV] = en_q.acv;
        fl_byte         = '0;
        fl_byte[FL_WDT] = fl_q.wdt;
        fl_byte[FL_OSC] = fl_q.osc;
        fl_byte[FL_POR] = fl_q.por;
        fl_byte[FL_PIN] = fl_q.pin;
        fl_byte[FL_NMI] = fl_q.nmi;
    end

    always_comb begin
        if (addr_i == EN_ADDR) begin
            rdata_o = en_byte;
        end else if (addr_i == FL_ADDR) begin
            rdata_o = fl_byte;
        end else begin
            rdata_o = '0;
        end
    end

    always_comb begin
        src_flag = '0;
        src_en   = '0;
        src_qual = '1;
        src_flag[SRC_WDT] = fl_q.wdt;
        src_en[SRC_WDT]   = en_q.wdt;
        src_qual[SRC_WDT] = wdt_itmode_i;
        src_flag[SRC_OSC] = fl_q.osc;
        src_en[SRC_OSC]   = en_q.osc;
        src_flag[SRC_NMI] = fl_q.nmi;
        src_en[SRC_NMI]   = en_q.nmi;
        src_flag[SRC_ACV] = acv_flag_i;
        src_en[SRC_ACV]   = en_q.acv;
    end

    sysirq_req_gate #(.N(NSRC)) u_gate (
        .flag_i (src_flag),
        .en_i   (src_en),
        .qual_i (src_qual),
        .req_o  (src_req)
    );

    assign irq_wdt_o = src_req[SRC_WDT];
    assign irq_osc_o = src_req[SRC_OSC];
    assign irq_nmi_o = src_req[SRC_NMI];
    assign irq_acv_o = src_req[SRC_ACV];
endmodule

// File: rtl/sysirq_regs_chk.sv
module sysirq_regs_chk (
    input logic       clk,
    input logic       rst_por_n,
    input logic       puc_i,
    input logic       pin_rst_i,
    input logic [7:0] addr_i,
    input logic [7:0] rdata_o,
    input logic       wdt_evt_i,
    input logic       nmi_evt_i,
    input logic       wdt_itmode_i,
    input logic       irq_wdt_o,
    input logic [7:0] en_byte,
    input logic [7:0] fl_byte
);
    AST_ABSENT_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_por_n)
        ((rdata_o & 8'hC0) == 8'h00) && ((fl_byte & 8'hE0) == 8'h00)); // R2
    AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_por_n)
        (addr_i != 8'h00 && addr_i != 8'h02) |-> rdata_o == 8'h00); // R1
    AST_PUC_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_por_n)
        (puc_i || pin_rst_i) |=> en_byte == 8'h00); // R4
    AST_PUC_SETS_OSC: assert property (@(posedge clk) disable iff (!rst_por_n)
        (puc_i || pin_rst_i) |=> fl_byte[1] && !fl_byte[4]); // R4
    AST_PUC_KEEPS_POR: assert property (@(posedge clk) disable iff (!rst_por_n)
        (puc_i || pin_rst_i) |=> fl_byte[2] == $past(fl_byte[2])); // R4
    AST_PIN_MARKS: assert property (@(posedge clk) disable iff (!rst_por_n)
        pin_rst_i |=> fl_byte[3]); // R5
    AST_PIN_CLEARS_WDT: assert property (@(posedge clk) disable iff (!rst_por_n)
        (pin_rst_i && !wdt_evt_i) |=> !fl_byte[0]); // R5
    AST_WDT_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_por_n)
        wdt_evt_i |=> fl_byte[0]); // R7
    AST_NMI_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_por_n)
        (nmi_evt_i && !puc_i && !pin_rst_i) |=> fl_byte[4]); // R7
    AST_WDT_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_por_n)
        !wdt_itmode_i |-> !irq_wdt_o); // R9
endmodule

bind sysirq_regs sysirq_regs_chk u_chk (
    .clk          (clk),
    .rst_por_n    (rst_por_n),
    .puc_i        (puc_i),
    .pin_rst_i    (pin_rst_i),
    .addr_i       (addr_i),
    .rdata_o      (rdata_o),
    .wdt_evt_i    (wdt_evt_i),
    .nmi_evt_i    (nmi_evt_i),
    .wdt_itmode_i (wdt_itmode_i),
    .irq_wdt_o    (irq_wdt_o),
    .en_byte      (en_byte),
    .fl_byte      (fl_byte)
);

// File: tb/sysirq_regs_tb.sv
`timescale 1ns/1ps
module sysirq_regs_tb;
    logic       clk = 1'b0;
    logic       rst_por_n = 1'b0;
    logic       puc_i = 1'b0, pin_rst_i = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic       wr_en_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       wdt_evt_i = 1'b0, osc_fault_i = 1'b0, nmi_evt_i = 1'b0;
    logic       acv_flag_i = 1'b0, wdt_itmode_i = 1'b0;
    logic       irq_wdt_o, irq_osc_o, irq_nmi_o, irq_acv_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sysirq_regs u_dut (
        .clk(clk), .rst_por_n(rst_por_n), .puc_i(puc_i), .pin_rst_i(pin_rst_i),
        .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .wdt_evt_i(wdt_evt_i), .osc_fault_i(osc_fault_i), .nmi_evt_i(nmi_evt_i),
        .acv_flag_i(acv_flag_i), .wdt_itmode_i(wdt_itmode_i),
        .irq_wdt_o(irq_wdt_o), .irq_osc_o(irq_osc_o), .irq_nmi_o(irq_nmi_o),
        .irq_acv_o(irq_acv_o)
    );

    // behavioural reference: two bytes kept as integers
    int m_en, m_fl;
    always @(posedge clk or negedge rst_por_n) begin
        int ne, nf;
        bit any_rst;
        if (!rst_por_n) begin
            m_en <= 0;
            m_fl <= 'h06;
        end else begin
            ne = m_en; nf = m_fl;
            any_rst = puc_i || pin_rst_i;
            if (wr_en_i && !any_rst && addr_i == 8'h00) ne = wdata_i & 'h33;
            if (wr_en_i && !any_rst && addr_i == 8'h02) nf = wdata_i & 'h1F;
            if (any_rst) ne = 0;
            if (wdt_evt_i)   nf = nf | 'h01;
            if (osc_fault_i) nf = nf | 'h02;
            if (nmi_evt_i)   nf = nf | 'h10;
            if (any_rst) nf = (nf & ~'h10) | 'h02;
            if (pin_rst_i) begin
                nf = nf | 'h08;
                if (!wdt_evt_i) nf = nf & ~'h01;
            end
            m_en <= ne;
            m_fl <= nf;
        end
    end

    function automatic int m_read(input logic [7:0] a);
        if (a == 8'h00) return m_en;
        if (a == 8'h02) return m_fl;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            int ereq;
            ereq = {m_fl[0] & m_en[0] & wdt_itmode_i, m_fl[1] & m_en[1],
                    m_fl[4] & m_en[4], acv_flag_i & m_en[5]};
            chk("R1 read data vs model", rdata_o, m_read(addr_i));
            chk("R8 R9 requests vs model",
                {irq_wdt_o, irq_osc_o, irq_nmi_o, irq_acv_o}, ereq);
        end
    end

    task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                       input bit we, input bit oe, input bit ne,
                       input bit pu, input bit pr);
        @(negedge clk); #1;
        wr_en_i = wr; addr_i = a; wdata_i = d;
        wdt_evt_i = we; osc_fault_i = oe; nmi_evt_i = ne;
        puc_i = pu; pin_rst_i = pr;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string tag);
        cyc(0, a, 8'hA5, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(tag, rdata_o, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_por_n = 1'b1;
        rd(8'h00, 'h00, "R3 enable after power-on");
        rd(8'h02, 'h06, "R3 flags after power-on");
        cyc(1, 8'h00, 8'hFF, 0, 0, 0, 0, 0);
        rd(8'h00, 'h33, "R2 enable absent bits");
        cyc(1, 8'h02, 8'hFF, 0, 0, 0, 0, 0);
        rd(8'h02, 'h1F, "R2 flag absent bits");
        cyc(1, 8'h02, 8'h00, 0, 0, 0, 0, 0);
        rd(8'h02, 'h00, "R6 software clears power-on flag");
        rd(8'h01, 'h00, "R1 address 0x01 reads zero");
        rd(8'h03, 'h00, "R1 address 0x03 reads zero");
        cyc(0, 8'h02, 8'h00, 0, 0, 1, 0, 0);
        rd(8'h02, 'h10, "R7 nmi event sets flag");
        chk("R8 nmi request", irq_nmi_o, 1);
        cyc(0, 8'h02, 8'h00, 1, 0, 0, 0, 0);
        rd(8'h02, 'h11, "R7 watchdog event sets flag");
        chk("R9 watchdog request blocked outside interval mode", irq_wdt_o, 0);
        wdt_itmode_i = 1'b1;
        @(negedge clk);
        chk("R9 watchdog request in interval mode", irq_wdt_o, 1);
        cyc(1, 8'h02, 8'h00, 0, 1, 0, 0, 0);
        rd(8'h02, 'h02, "R7 fault event beats clearing write");
        chk("R8 oscillator request", irq_osc_o, 1);
        acv_flag_i = 1'b1;
        @(negedge clk);
        chk("R8 access-violation request", irq_acv_o, 1);
        cyc(1, 8'h00, 8'h00, 0, 0, 0, 0, 0);
        rd(8'h00, 'h00, "R6 enable write");
        chk("R8 access-violation masked", irq_acv_o, 0);
        cyc(1, 8'h00, 8'h33, 0, 0, 0, 0, 0);
        cyc(1, 8'h02, 8'h1D, 0, 0, 0, 0, 0);
        cyc(1, 8'h00, 8'hFF, 0, 0, 0, 1, 0);
        rd(8'h00, 'h00, "R4 clear wins over write");
        rd(8'h02, 'h0F, "R4 flag byte after power-up-clear");
        cyc(0, 8'h00, 8'h00, 0, 0, 0, 0, 1);
        rd(8'h02, 'h0E, "R5 pin reset clears watchdog flag");
        cyc(1, 8'h02, 8'h00, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 8'h00, 1, 0, 0, 0, 1);
        rd(8'h02, 'h0B, "R5 pin reset with watchdog event");
        cyc(0, 8'h00, 8'h00, 0, 0, 0, 1, 0);
        rd(8'h02, 'h0B, "R5 plain clear keeps cause flags");
        @(negedge clk); #1 rst_por_n = 1'b0;
        @(negedge clk); #1 addr_i = 8'h02;
        @(negedge clk);
        chk("R3 flags during power-on", rdata_o, 'h06);
        #1 rst_por_n = 1'b1;
        rd(8'h02, 'h06, "R3 flags after second power-on");
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 100;
            cyc(($urandom % 3) == 0, 8'($urandom % 5), 8'($urandom),
                ($urandom % 9) == 0, ($urandom % 9) == 0, ($urandom % 7) == 0,
                r < 3, r > 97);
            wdt_itmode_i = ($urandom % 4) != 0;
            acv_flag_i = ($urandom % 2) != 0;
        end
        cyc(0, 8'h00, 8'h00, 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule